// File: doc/BRIEF.md
# Pipelined Vectoring CORDIC (Cartesian to Polar)

This block turns a signed Cartesian pair into a magnitude and an angle using only shifts, adds and one constant multiply. A sample is offered with a strobe, one pair per clock at most. A front stage folds the vector into the right half-plane, where the iteration converges. A chain of identical micro-rotation stages then walks the vector onto the positive x-axis and adds up the angle it turned through. A final stage restores the true quadrant and scales the magnitude by the inverse of the iteration gain.

Every result leaves the block a fixed number of cycles after its sample entered. The output strobe copies the input strobe pattern exactly, gaps included. Both results use a fixed-point format with four fractional bits. The angle is in degrees, so one output LSB is 1/16 of a unit or of a degree.

Top module: `cordic_polar`

## Requirements
- R1: While reset is held, and until the first sample emerges after it, `outValid` is 0 and both `rOut` and `aOut` read 0.
- R2: A sample taken with `inValid` high at a rising edge produces `outValid` high exactly 18 rising edges later. No output strobe occurs without a matching sample. Back-to-back samples give back-to-back results in the same order.
- R3: `rOut` is an unsigned magnitude with 4 fractional bits. It is within 3 LSB of round(16·sqrt(x²+y²)).
- R4: `aOut` is a signed two's-complement angle in degrees with 4 fractional bits. It is within 2 LSB of 16·atan2(y,x)·180/π, and always lies in [-2880, 2880].
- R5: Inputs with negative x, in the second and third quadrants, get the correct angle. A vector on the negative x-axis with y = 0 reads +180° (`aOut` = 2880).
- R6: A vector on the y-axis with x = 0 reads +90° (1440) for y > 0 and −90° (−1440) for y < 0.
- R7: Full-scale inputs, including −32768 on either axis, do not overflow. For example, (−32768, −32768) gives `rOut` ≈ 741455 and `aOut` = −2160.
- R8: The input (0, 0) gives `rOut` = 0. The angle in that case is unspecified.
- R9: While `outValid` is low, `rOut` and `aOut` hold the last result that was delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Sample strobe for xIn/yIn |
| xIn | input | 16 | Signed x coordinate |
| yIn | input | 16 | Signed y coordinate |
| outValid | output | 1 | Result strobe |
| rOut | output | 20 | Magnitude, unsigned, 4 fractional bits |
| aOut | output | 20 | Angle in degrees, signed, 4 fractional bits |

## Verification
The assertions assume that every input pair is a legal 16-bit signed value. They also assume the strobe is low or high at each edge and never unknown. Under those conditions, the folded x stays non-negative through every stage, and the rounded angle stays within ±180°. The stimulus drives only defined values on the falling edge. It mixes fixed corner vectors (the axes, full scale, zero and all four quadrants) with bursts and gaps of random full-range pairs. The checks compare each result against a real-number model with small tolerances. The zero vector's angle is left unchecked.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  localparam int IN_W   = 16;             // input word width
  localparam int ITER   = 16;             // micro-rotation stages
  localparam int FRAC   = 4;              // fractional bits at the outputs
  localparam int GUARD  = 4;              // extra internal fraction bits
  localparam int ANG_F  = 12;             // angle accumulator fraction bits
  localparam int SH     = FRAC + GUARD;   // input pre-scale
  localparam int W      = IN_W + SH + 3;  // x/y width incl. growth
  localparam int ZW     = ANG_F + 10;     // angle accumulator width
  localparam int OUT_W  = IN_W + FRAC;    // result width
  localparam int LAT    = ITER + 2;       // pre + stages + post
  localparam int GAIN_Q = 16;             // fraction bits of gain constant
  localparam int GAIN_C = 39797;          // round(2^16 / 1.6467602)
  localparam int PW     = W + GAIN_Q + 1; // product width

  typedef struct packed {
    logic [LAT-1:0] load;   // level k captures this cycle
    logic [LAT-1:0] full;   // level k holds a live sample
  } pipeCtl_t;

  // atan(2^-i) in degrees, scaled by 2^ANG_F
  function automatic logic signed [ZW-1:0] atanStep(input int i);
    int v;
    case (i)
      0:  v = 184320;
      1:  v = 108810;
      2:  v = 57492;
      3:  v = 29184;
      4:  v = 14649;
      5:  v = 7331;
      6:  v = 3667;
      7:  v = 1833;
      8:  v = 917;
      9:  v = 458;
      10: v = 229;
      11: v = 115;
      12: v = 57;
      13: v = 29;
      14: v = 14;
      15: v = 7;
      default: v = 234684 >>> i;
    endcase
    return ZW'(v);
  endfunction
endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl import cordic_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output pipeCtl_t ctl
);
  logic [LAT-1:0] full;

  always_ff @(posedge clk) begin
    if (!rstN) full <= '0;
    else       full <= {full[LAT-2:0], inValid};
  end

  assign ctl.load = {full[LAT-2:0], inValid};
  assign ctl.full = full;
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage import cordic_pkg::*; #(
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic                 full,
  input  logic signed [W-1:0]  xI,
  input  logic signed [W-1:0]  yI,
  input  logic signed [ZW-1:0] zI,
  input  logic [1:0]           corrI,
  output logic signed [W-1:0]  xO,
  output logic signed [W-1:0]  yO,
  output logic signed [ZW-1:0] zO,
  output logic [1:0]           corrO
);
  localparam logic signed [ZW-1:0] STEP = atanStep(IDX);
  logic signed [W-1:0] xSh, ySh;
  logic yNeg;

  assign xSh  = xI >>> IDX;
  assign ySh  = yI >>> IDX;
  assign yNeg = yI[W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xO <= '0; yO <= '0; zO <= '0; corrO <= '0;
    end else if (load) begin
      if (!yNeg) begin
        xO <= xI + ySh;
        yO <= yI - xSh;
        zO <= zI + STEP;
      end else begin
        xO <= xI - ySh;
        yO <= yI + xSh;
        zO <= zI - STEP;
      end
      corrO <= corrI;
    end
  end

  // the folded vector never leaves the right half-plane
  assert_x_nonneg_R3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !xO[W-1]);
endmodule

// File: rtl/cordic_dpath.sv
module cordic_dpath import cordic_pkg::*; (
  input  logic                    clk,
  input  logic                    rstN,
  input  pipeCtl_t                ctl,
  input  logic signed [IN_W-1:0]  xIn,
  input  logic signed [IN_W-1:0]  yIn,
  output logic [OUT_W-1:0]        rOut,
  output logic signed [OUT_W-1:0] aOut
);
  localparam logic signed [ZW-1:0] HALF = ZW'(180 <<< ANG_F);
  localparam int ASH = ANG_F - FRAC;
  localparam int MSH = GAIN_Q + GUARD;

  logic signed [W-1:0]  xExt, yExt, xPre, yPre;
  logic [1:0]           corrPre;
  logic signed [W-1:0]  xs [0:ITER];
  logic signed [W-1:0]  ys [0:ITER];
  logic signed [ZW-1:0] zs [0:ITER];
  logic [1:0]           cs [0:ITER];

  // pre-processor: fold left half-plane onto the right one
  assign xExt = W'(xIn) <<< SH;
  assign yExt = W'(yIn) <<< SH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xPre <= '0; yPre <= '0; corrPre <= '0;
    end else if (ctl.load[0]) begin
      xPre    <= xIn[IN_W-1] ? -xExt : xExt;
      yPre    <= xIn[IN_W-1] ? -yExt : yExt;
      corrPre <= {xIn[IN_W-1], yIn[IN_W-1]};  // {folded, y negative}
    end
  end

  assign xs[0] = xPre;
  assign ys[0] = yPre;
  assign zs[0] = '0;
  assign cs[0] = corrPre;

  assert_pre_halfplane_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.full[0] |-> !xPre[W-1]);

  for (genvar k = 0; k < ITER; k++) begin : gStage
    cordic_stage #(.IDX(k)) uStage (
      .clk(clk), .rstN(rstN),
      .load(ctl.load[k+1]), .full(ctl.full[k+1]),
      .xI(xs[k]), .yI(ys[k]), .zI(zs[k]), .corrI(cs[k]),
      .xO(xs[k+1]), .yO(ys[k+1]), .zO(zs[k+1]), .corrO(cs[k+1])
    );
  end

  // post-processor: quadrant restore, rounding, gain compensation
  logic signed [ZW-1:0] zFix, zRnd;
  logic [PW-1:0]        prod, prodRnd;

  always_comb begin
    zFix = zs[ITER];
    if (cs[ITER][1]) zFix = cs[ITER][0] ? zFix - HALF : zFix + HALF;
  end

  assign zRnd    = (zFix + ZW'(1 <<< (ASH - 1))) >>> ASH;
  assign prod    = PW'($unsigned(xs[ITER])) * PW'(GAIN_C);
  assign prodRnd = (prod + PW'(1 <<< (MSH - 1))) >> MSH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rOut <= '0; aOut <= '0;
    end else if (ctl.load[LAT-1]) begin
      rOut <= prodRnd[OUT_W-1:0];
      aOut <= zRnd[OUT_W-1:0];
    end
  end

  assert_angle_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load[LAT-1] |-> (zRnd <= ZW'(180 * 16) && zRnd >= -ZW'(180 * 16)));

  assert_mag_fits_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load[LAT-1] |-> (prodRnd[PW-1:OUT_W] == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load[LAT-1] |=> ($stable(rOut) && $stable(aOut)));
endmodule

// File: rtl/cordic_polar.sv
module cordic_polar import cordic_pkg::*; (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  xIn,
  input  logic signed [IN_W-1:0]  yIn,
  output logic                    outValid,
  output logic [OUT_W-1:0]        rOut,
  output logic signed [OUT_W-1:0] aOut
);
  pipeCtl_t ctl;

  cordic_ctrl uCtrl (.clk(clk), .rstN(rstN), .inValid(inValid), .ctl(ctl));

  cordic_dpath uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .xIn(xIn), .yIn(yIn), .rOut(rOut), .aOut(aOut)
  );

  assign outValid = ctl.full[LAT-1];
endmodule

// File: tb/sim_cordic_polar.sv
`timescale 1ns/1ps
module sim_cordic_polar;
  localparam int LATENCY = 18;
  localparam real PI = 3.14159265358979;

  logic clk = 0, rstN = 0, inValid = 0;
  logic signed [15:0] xIn = 0, yIn = 0;
  logic outValid;
  logic [19:0] rOut;
  logic signed [19:0] aOut;

  cordic_polar u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .xIn(xIn),
                   .yIn(yIn), .outValid(outValid), .rOut(rOut), .aOut(aOut));

  always #2.5 clk = ~clk;

  typedef struct { int cyc; int er; int ea; bit chkA; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, failures = 0;
  int lastR = 0, lastA = 0;
  bit running = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // reference model, one comparison per clock
  always @(negedge clk) begin
    if (running) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        int d;
        e = q.pop_front();
        check(outValid === 1'b1, {"R2 result strobe ", e.tag}, int'(outValid), 1);
        d = int'(rOut) - e.er;
        check(d <= 3 && d >= -3, {"R3 magnitude ", e.tag}, int'(rOut), e.er);
        if (e.chkA) begin
          d = int'(aOut) - e.ea;
          check(d <= 2 && d >= -2, {"R4 angle ", e.tag}, int'(aOut), e.ea);
        end
        check(int'(aOut) <= 2880 && int'(aOut) >= -2880, "R4 angle range",
              int'(aOut), 2880);
        lastR = int'(rOut);
        lastA = int'(aOut);
      end else begin
        check(outValid === 1'b0, "R2 no spurious strobe", int'(outValid), 0);
        check(int'(rOut) == lastR && int'(aOut) == lastA, "R9 hold while idle",
              int'(rOut) ^ lastR, 0);
      end
    end
  end

  task automatic send(input int x, input int y, input bit chkA, input string tag);
    exp_t e;
    real r, a;
    @(negedge clk);
    inValid = 1;
    xIn = 16'(x);
    yIn = 16'(y);
    r = $sqrt(real'(x) * x + real'(y) * y) * 16.0;
    a = $atan2(real'(y), real'(x)) * 180.0 / PI * 16.0;
    e.cyc = cyc + LATENCY;
    e.er = int'(r);
    e.ea = int'(a);
    e.chkA = chkA;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 0;
      xIn = 16'($urandom);
      yIn = 16'($urandom);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outValid === 1'b0 && rOut == 0 && aOut == 0, "R1 reset state",
            int'(rOut) + int'(aOut) + int'(outValid), 0);
    end
    rstN = 1;
    running = 1;
    idle(3);
    // R3 / R4 first quadrant
    send(3000, 4000, 1, "Q1 3-4-5");
    send(1, 1, 1, "Q1 unit diagonal");
    send(20000, 100, 1, "Q1 shallow");
    // R5 left half-plane
    send(-3000, 4000, 1, "R5 Q2");
    send(-3000, -4000, 1, "R5 Q3");
    send(3000, -4000, 1, "Q4");
    send(-1234, 0, 1, "R5 negative x-axis");
    idle(2);
    // R6 y-axis
    send(0, 500, 1, "R6 +y axis");
    send(0, -500, 1, "R6 -y axis");
    // R7 full scale
    send(-32768, -32768, 1, "R7 min corner");
    send(32767, 32767, 1, "R7 max corner");
    send(-32768, 0, 1, "R7 min x");
    send(32767, -32768, 1, "R7 mixed");
    send(0, -32768, 1, "R7 min y");
    // R8 zero vector
    send(0, 0, 0, "R8 zero");
    idle(25);
    // R2 / R9 bursts and gaps of random pairs
    for (int b = 0; b < 40; b++) begin
      int len = 1 + int'($urandom % 6);
      for (int i = 0; i < len; i++) begin
        int x = int'(16'sh0 + $signed(16'($urandom)));
        int y = int'(16'sh0 + $signed(16'($urandom)));
        send(x, y, (x != 0 || y != 0), "random burst");
      end
      idle(int'($urandom % 4));
    end
    idle(LATENCY + 5);
    check(q.size() == 0, "R2 every sample returned", q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule